// File: doc/BRIEF.md
# Retention-Memory Boot Copy Engine

This block keeps a short boot program in a small retention memory. That memory stays powered while the rest of the device sleeps. On command, the block copies a programmed number of 32-bit words from the retention memory into a processor's instruction memory, one word per clock whenever the instruction memory accepts it. Software loads the retention memory through a dedicated write port. It then programs a source word index, a destination word address and a word count over a simple register bus, and starts the copy by setting a start bit. That bit reads back as 1 for as long as the copy is in flight.

The block can also be armed. When it is armed, every power-up pulse replays the most recently programmed copy without software taking part. This lets the boot program be put back into instruction memory after each sleep. The retention memory contents can be read back through an address window on the register bus.

Register map, by byte offset on the register bus:

| Offset | Contents |
|--------|----------|
| 0x000 | control: bit 31 is start/busy, bit 30 is arm |
| 0x004 | source word index |
| 0x008 | destination word address |
| 0x00C | word count |
| 0x010 | status: bit 0 is done |
| 0x400 + 4·i | retention word i |

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, the control, source, destination, count and status registers all read 0, and `imem_valid` is low.
- R2: Writing the control register at offset 0x000 with bit 31 set starts a copy. Word i of the copy carries retention word ((source + i) mod RAM_DEPTH) to destination address (destination + i), for i from 0 to count−1, in increasing order.
- R3: Control bit 31 reads 1 while a copy is in progress and 0 once it is done. Status bit 0 at offset 0x010 reads 1 after a copy completes, and `imem_valid` is never high while the engine is idle.
- R4: Starting a new copy of nonzero count clears status bit 0, which stays 0 until that copy completes.
- R5: A start with count 0 issues no write to instruction memory and sets status bit 0.
- R6: While `imem_valid` is high and `imem_ready` is low, `imem_valid`, `imem_addr` and `imem_data` hold. With `imem_ready` held high, a copy of N words keeps `imem_valid` high for exactly N cycles.
- R7: Writes to the source (0x004), destination (0x008) and count (0x00C) registers while a copy is in progress are ignored. Reading them back afterwards returns the earlier values.
- R8: Control bit 30 arms replay. When it is set, each `pwr_up` pulse that arrives while idle starts the last programmed copy. When bit 30 is clear, `pwr_up` starts nothing.
- R9: Retention word i, written through the load port at index i, reads back on the register bus at byte offset 0x400 + 4·i. Register reads return data one clock after the address is presented.
- R10: A start request made while a copy is in progress is ignored. The running copy issues exactly its count of writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register bus write strobe |
| reg_addr | input | REG_AW | Register bus byte address; the upper half is the retention window |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Register bus read data, one cycle after the address |
| ret_we | input | 1 | Retention memory load strobe |
| ret_waddr | input | RAM_AW | Retention memory load word index |
| ret_wdata | input | 32 | Retention memory load data |
| pwr_up | input | 1 | Power-up event pulse |
| imem_valid | output | 1 | Instruction memory write request |
| imem_addr | output | DST_AW | Instruction memory word address |
| imem_data | output | 32 | Instruction memory write data |
| imem_ready | input | 1 | Instruction memory accepts the write this cycle |

## Verification
The embedded properties check the following on every cycle:
- a stalled write holds its address and data (R6);
- accepted writes step their destination by one (R2);
- busy and done never overlap, and no write appears while idle (R3);
- the configuration stays frozen while busy (R7);
- an armed power-up pulse with nonzero count raises busy (R8).

Other behaviours only the bench scenarios can show:
- the data actually moved matches the retention contents;
- the exact write count;
- zero-count completion;
- the clearing of done on restart;
- ignored restarts;
- the absence of any replay when unarmed.

The bench shows these with random copies under random back-pressure, together with directed stall, arm and zero-count cases.

// File: rtl/bcopy_pkg.sv
package bcopy_pkg;
  // register byte offsets
  localparam int unsigned CSR_CTRL = 32'h000;
  localparam int unsigned CSR_SRC  = 32'h004;
  localparam int unsigned CSR_DST  = 32'h008;
  localparam int unsigned CSR_CNT  = 32'h00C;
  localparam int unsigned CSR_STAT = 32'h010;
  // field positions
  localparam int GO_BIT   = 31;
  localparam int ARM_BIT  = 30;
  localparam int DONE_BIT = 0;
endpackage

// File: rtl/bcopy_ret_ram.sv
module bcopy_ret_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read with enable: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bcopy_regs.sv
module bcopy_regs
  import bcopy_pkg::*;
#(
  parameter int RAM_AW = 8,
  parameter int DST_AW = 12,
  parameter int CNT_W  = 9,
  parameter int REG_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              pwr_up,
  input  logic [31:0]       ram_rdata,
  output logic              start,
  output logic [RAM_AW-1:0] src_q,
  output logic [DST_AW-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              host_re,
  output logic [RAM_AW-1:0] host_raddr
);
  logic arm_q;
  logic win, win_q;
  logic hit_ctrl, hit_src, hit_dst, hit_cnt, hit_stat;
  logic [31:0] csr_nxt, csr_q;
  logic unused_bits;

  assign win      = reg_addr[REG_AW-1];
  assign hit_ctrl = reg_addr == REG_AW'(CSR_CTRL);
  assign hit_src  = reg_addr == REG_AW'(CSR_SRC);
  assign hit_dst  = reg_addr == REG_AW'(CSR_DST);
  assign hit_cnt  = reg_addr == REG_AW'(CSR_CNT);
  assign hit_stat = reg_addr == REG_AW'(CSR_STAT);

  // software start or armed power-up replay, only while idle (R2, R8, R10)
  assign start = !busy && ((reg_wr && hit_ctrl && reg_wdata[GO_BIT]) ||
                           (pwr_up && arm_q));

  assign host_re    = win && !busy;
  assign host_raddr = reg_addr[RAM_AW+1:2];
  assign unused_bits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (reg_wr && hit_ctrl) arm_q <= reg_wdata[ARM_BIT];
      if (reg_wr && !busy) begin            // R7: frozen while busy
        if (hit_src) src_q <= reg_wdata[RAM_AW-1:0];
        if (hit_dst) dst_q <= reg_wdata[DST_AW-1:0];
        if (hit_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    csr_nxt = '0;
    if (hit_ctrl) begin
      csr_nxt[GO_BIT]  = busy;
      csr_nxt[ARM_BIT] = arm_q;
    end
    if (hit_src)  csr_nxt = 32'(src_q);
    if (hit_dst)  csr_nxt = 32'(dst_q);
    if (hit_cnt)  csr_nxt = 32'(cnt_q);
    if (hit_stat) csr_nxt[DONE_BIT] = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q <= '0;
      win_q <= 1'b0;
    end else begin
      csr_q <= csr_nxt;
      win_q <= win;
    end
  end

  assign reg_rdata = win_q ? ram_rdata : csr_q;

  // R7: configuration cannot move while a copy runs
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q));

  // R8: an armed power-up with a nonzero count launches a copy
  p_replay_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && pwr_up && arm_q && cnt_q != '0) |=> busy);
endmodule

// File: rtl/bcopy_mover.sv
module bcopy_mover #(
  parameter int RAM_AW = 8,
  parameter int DST_AW = 12,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RAM_AW-1:0] src,
  input  logic [DST_AW-1:0] dst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dst_ready,
  output logic              busy,
  output logic              done,
  output logic              dst_valid,
  output logic [DST_AW-1:0] dst_addr,
  output logic              rd_en,
  output logic [RAM_AW-1:0] rd_addr
);
  logic              busy_q, done_q, vld_q;
  logic [CNT_W-1:0]  rem_q;
  logic [RAM_AW-1:0] sp_q;
  logic [DST_AW-1:0] dp_q, daddr_q;
  logic              advance;

  // output slot is free or being emptied this cycle
  assign advance = !vld_q || dst_ready;
  assign rd_en   = busy_q && (rem_q != '0) && advance;
  assign rd_addr = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      vld_q   <= 1'b0;
      rem_q   <= '0;
      sp_q    <= '0;
      dp_q    <= '0;
      daddr_q <= '0;
    end else if (start) begin
      if (cnt == '0) begin
        done_q <= 1'b1;                     // R5: nothing to move
      end else begin
        busy_q <= 1'b1;
        done_q <= 1'b0;                     // R4
        rem_q  <= cnt;
        sp_q   <= src;
        dp_q   <= dst;
      end
    end else if (busy_q) begin
      if (rd_en) begin
        vld_q   <= 1'b1;
        daddr_q <= dp_q;
        dp_q    <= dp_q + 1'b1;
        sp_q    <= sp_q + 1'b1;
        rem_q   <= rem_q - 1'b1;
      end else if (advance) begin           // last word taken
        vld_q  <= 1'b0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign dst_valid = vld_q;
  assign dst_addr  = daddr_q;

  // R6: a refused write keeps its address
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_addr)));

  // R3: no write request while idle
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dst_valid);

  // R3: busy and done are exclusive
  p_done_excl_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  // R2: consecutive accepted writes step the destination by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && dst_ready) |=> (!dst_valid || dst_addr == $past(dst_addr) + 1'b1));
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
  parameter int RAM_DEPTH = 256,
  parameter int DST_AW    = 12,
  localparam int RAM_AW   = $clog2(RAM_DEPTH),
  localparam int CNT_W    = RAM_AW + 1,
  localparam int REG_AW   = RAM_AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ret_we,
  input  logic [RAM_AW-1:0] ret_waddr,
  input  logic [31:0]       ret_wdata,
  input  logic              pwr_up,
  output logic              imem_valid,
  output logic [DST_AW-1:0] imem_addr,
  output logic [31:0]       imem_data,
  input  logic              imem_ready
);
  logic              busy, done, start;
  logic [RAM_AW-1:0] src_q, host_raddr, mv_raddr, ram_raddr;
  logic [DST_AW-1:0] dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              host_re, mv_re, ram_re;
  logic [31:0]       ram_q;

  bcopy_regs #(.RAM_AW(RAM_AW), .DST_AW(DST_AW), .CNT_W(CNT_W), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .done(done), .pwr_up(pwr_up), .ram_rdata(ram_q),
    .start(start), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .host_re(host_re), .host_raddr(host_raddr));

  bcopy_mover #(.RAM_AW(RAM_AW), .DST_AW(DST_AW), .CNT_W(CNT_W)) mover_i (
    .clk(clk), .rst(rst), .start(start), .src(src_q), .dst(dst_q), .cnt(cnt_q),
    .dst_ready(imem_ready), .busy(busy), .done(done), .dst_valid(imem_valid),
    .dst_addr(imem_addr), .rd_en(mv_re), .rd_addr(mv_raddr));

  // the engine owns the read port while busy, the window otherwise
  assign ram_re    = busy ? mv_re    : host_re;
  assign ram_raddr = busy ? mv_raddr : host_raddr;

  bcopy_ret_ram #(.DEPTH(RAM_DEPTH), .DW(32)) ram_i (
    .clk(clk), .we(ret_we), .waddr(ret_waddr), .wdata(ret_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q));

  assign imem_data = ram_q;

  // R6: a refused write keeps its data
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && !imem_ready) |=> $stable(imem_data));
endmodule

// File: tb/boot_copy_engine_tb_top.sv
module boot_copy_engine_tb_top;
  localparam int RAM_DEPTH = 256;
  localparam int DST_AW    = 12;
  localparam int RAM_AW    = 8;
  localparam int REG_AW    = 11;
  localparam logic [REG_AW-1:0] A_CTRL = 11'h000, A_SRC = 11'h004, A_DST = 11'h008,
                                A_CNT  = 11'h00C, A_STAT = 11'h010, A_WIN = 11'h400;

  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ret_we = 0;
  logic [RAM_AW-1:0] ret_waddr = '0;
  logic [31:0] ret_wdata = '0;
  logic pwr_up = 0;
  logic imem_valid, imem_ready = 1;
  logic [DST_AW-1:0] imem_addr;
  logic [31:0] imem_data;

  always #2.5 clk = ~clk;  // 200 MHz

  boot_copy_engine #(.RAM_DEPTH(RAM_DEPTH), .DST_AW(DST_AW)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ret_we(ret_we), .ret_waddr(ret_waddr), .ret_wdata(ret_wdata),
    .pwr_up(pwr_up), .imem_valid(imem_valid), .imem_addr(imem_addr), .imem_data(imem_data),
    .imem_ready(imem_ready));

  int total = 0, fails = 0, cyc = 0;
  int rdy_mode = 0;           // 0 always ready, 1 random, 2 never
  logic [31:0] ret_model [RAM_DEPTH];
  logic [DST_AW-1:0] log_addr [1024];
  logic [31:0] log_data [1024];
  int n_acc = 0, vld_cycles = 0, stall_bad = 0;
  logic hold_pend = 0;
  logic [DST_AW-1:0] hold_addr;
  logic [31:0] hold_data;
  logic [31:0] rd;
  int seed_dummy;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // destination model, sampled away from the active edge
  always @(negedge clk) begin
    if (rdy_mode == 0) imem_ready = 1'b1;
    else if (rdy_mode == 1) imem_ready = 1'($urandom % 2);
    else imem_ready = 1'b0;
    if (hold_pend && !(imem_valid && imem_addr == hold_addr && imem_data == hold_data))
      stall_bad++;
    hold_pend = imem_valid && !imem_ready;
    hold_addr = imem_addr;
    hold_data = imem_data;
    if (imem_valid) vld_cycles++;
    if (imem_valid && imem_ready) begin
      if (n_acc < 1024) begin
        log_addr[n_acc] = imem_addr;
        log_data[n_acc] = imem_data;
      end
      n_acc++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic reg_write(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [REG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic ret_load(input int idx, input logic [31:0] d);
    @(negedge clk); ret_we = 1; ret_waddr = RAM_AW'(idx); ret_wdata = d;
    ret_model[idx] = d;
    @(negedge clk); ret_we = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      reg_read(A_CTRL, v);
      if (!v[31]) break;
    end
  endtask

  function automatic logic [31:0] exp_word(input int src, input int i);
    return ret_model[(src + i) % RAM_DEPTH];
  endfunction

  // compare the logged writes with the expected copy
  task automatic verify_copy(input int src, input int dst, input int cnt, input string req);
    int bad = 0;
    check(n_acc == cnt, {req, " write count"}, 32'(n_acc), 32'(cnt));
    for (int i = 0; i < cnt && i < n_acc; i++)
      if (log_addr[i] != DST_AW'(dst + i) || log_data[i] != exp_word(src, i)) bad++;
    check(bad == 0, {req, " data/address order"}, 32'(bad), 0);
  endtask

  task automatic run_copy(input int src, input int dst, input int cnt, input int mode, input string req);
    logic [31:0] v;
    rdy_mode = mode;
    reg_write(A_SRC, 32'(src));
    reg_write(A_DST, 32'(dst));
    reg_write(A_CNT, 32'(cnt));
    n_acc = 0; vld_cycles = 0;
    reg_write(A_CTRL, 32'h8000_0000);
    wait_idle();
    verify_copy(src, dst, cnt, req);
    reg_read(A_STAT, v);
    check(v[0] == 1'b1, "R3 done after copy", v, 32'h1);
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    reg_read(A_CTRL, rd); check(rd == 0, "R1 ctrl", rd, 0);
    reg_read(A_SRC, rd);  check(rd == 0, "R1 src", rd, 0);
    reg_read(A_DST, rd);  check(rd == 0, "R1 dst", rd, 0);
    reg_read(A_CNT, rd);  check(rd == 0, "R1 cnt", rd, 0);
    reg_read(A_STAT, rd); check(rd == 0, "R1 status", rd, 0);
    check(imem_valid == 0, "R1 imem_valid", 32'(imem_valid), 0);

    // R5 zero count: done set, no writes
    n_acc = 0;
    reg_write(A_CTRL, 32'h8000_0000);
    repeat (5) @(negedge clk);
    check(n_acc == 0, "R5 zero count writes", 32'(n_acc), 0);
    reg_read(A_STAT, rd); check(rd[0] == 1'b1, "R5 zero count done", rd, 1);
    reg_read(A_CTRL, rd); check(rd[31] == 1'b0, "R5 not busy", rd, 0);

    // load retention memory
    for (int i = 0; i < RAM_DEPTH; i++) ret_load(i, $urandom);

    // R9 window readback
    begin
      int bad = 0;
      for (int i = 0; i < RAM_DEPTH; i += 17) begin
        reg_read(A_WIN + REG_AW'(4 * i), rd);
        if (rd != ret_model[i]) bad++;
      end
      check(bad == 0, "R9 window readback", 32'(bad), 0);
    end

    // R2 + R6 throughput with ready always high
    run_copy(5, 32, 20, 0, "R2 directed");
    check(vld_cycles == 20, "R6 one word per cycle", 32'(vld_cycles), 20);

    // R2 wrap of the source index
    run_copy(250, 100, 12, 1, "R2 source wrap");

    // R4, R7, R10 while stalled
    rdy_mode = 2;
    reg_write(A_SRC, 32'd10);
    reg_write(A_DST, 32'd200);
    reg_write(A_CNT, 32'd8);
    n_acc = 0;
    reg_write(A_CTRL, 32'h8000_0000);
    reg_read(A_CTRL, rd); check(rd[31] == 1'b1, "R3 busy while running", rd, 32'h8000_0000);
    reg_read(A_STAT, rd); check(rd[0] == 1'b0, "R4 done cleared on start", rd, 0);
    reg_write(A_SRC, 32'd77);
    reg_write(A_DST, 32'd999);
    reg_write(A_CNT, 32'd3);
    reg_write(A_CTRL, 32'h8000_0000);     // R10 restart while busy
    reg_read(A_SRC, rd); check(rd == 10, "R7 src frozen", rd, 10);
    reg_read(A_DST, rd); check(rd == 200, "R7 dst frozen", rd, 200);
    reg_read(A_CNT, rd); check(rd == 8, "R7 cnt frozen", rd, 8);
    rdy_mode = 1;
    wait_idle();
    verify_copy(10, 200, 8, "R10 single run");
    check(stall_bad == 0, "R6 hold under stall", 32'(stall_bad), 0);

    // R8 armed replay
    run_copy(40, 600, 6, 0, "R2 setup");
    n_acc = 0;
    reg_write(A_CTRL, 32'h4000_0000);
    repeat (5) @(negedge clk);
    check(n_acc == 0, "R8 arming alone starts nothing", 32'(n_acc), 0);
    @(negedge clk); pwr_up = 1;
    @(negedge clk); pwr_up = 0;
    reg_read(A_CTRL, rd); check(rd[31:30] == 2'b11, "R8 busy on replay", rd, 32'hC000_0000);
    wait_idle();
    verify_copy(40, 600, 6, "R8 replay");
    n_acc = 0;
    reg_write(A_CTRL, 32'h0);
    @(negedge clk); pwr_up = 1;
    @(negedge clk); pwr_up = 0;
    repeat (12) @(negedge clk);
    check(n_acc == 0, "R8 unarmed pulse ignored", 32'(n_acc), 0);

    // random copies under random back-pressure
    for (int it = 0; it < 12; it++) begin
      int s, d, c, m;
      s = int'($urandom % RAM_DEPTH);
      d = int'($urandom % (1 << DST_AW));
      c = 1 + int'($urandom % 40);
      m = int'($urandom % 2);
      run_copy(s, d, c, m, "R2 random");
    end
    check(stall_bad == 0, "R6 hold under random stall", 32'(stall_bad), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule